// File: doc/BRIEF.md
# Signature Accelerator Control Sequencer

This block is the software-facing front end of an elliptic-curve signature accelerator. A simple memory-mapped write bus programs a configuration word and issues self-clearing command pulses. Reads return data combinationally from the address. The arithmetic engine sits outside the block. It is started by a one-cycle pulse and answers with a done strobe, a verify-pass flag and a flag that reports k was reduced. The block keeps the operation phase, the result bits and a two-source interrupt bank.

A job runs through four phases. Software first writes the configuration while the block is idle and then issues start. The block enters the load phase and waits while the operands are written into memories outside it. Load-done starts the engine and moves the block to busy. When the engine finishes, the block records the outcome and raises the calculation-done interrupt. For generate and export jobs it then waits in the get phase until software signals get-done after it has read the outputs. A verify job returns straight to idle.

Top module: `sigacc_ctrl`

## Requirements
- R1: After reset every register reads zero, except the version word at offset 0xFC, which reads 36716656. The phase is idle, and irq_o and eng_start_o are low.
- R2: The configuration word at offset 0x04 holds bits 21:0 and reads back with bits 31:22 as zero. It appears on cfg_o. Its fields are: mode in bits 1:0 (0 verify, 1 generate, 2 export, 3 invalid), curve select in bit 2, software k in bit 3, software z in bit 4, deterministic k in bit 5, and iteration count minus one in bits 21:6.
- R3: A write to the configuration word has no effect unless the phase is idle.
- R4: The command register at offset 0x1C has start in bit 0, load-done in bit 1 and get-done in bit 2. Each bit acts for the single write cycle only, and the register always reads zero.
- R5: The phase reads at offset 0x20, bits 1:0, as 0 idle, 1 load, 2 get and 3 busy. Start in idle moves the phase to load. Load-done in load moves it to busy, and eng_start_o is high for exactly the first busy cycle.
- R6: An engine done strobe in busy moves the phase to get for modes 1 and 2, and to idle for mode 0. Get-done in get returns the phase to idle.
- R7: A command that does not match the current phase is ignored, and so is an engine done strobe outside busy. A start while the mode is 3 leaves the phase idle.
- R8: The result word at offset 0x24 captures eng_pass_i in bit 0 and eng_kbig_i in bit 1 on the engine done strobe. Both bits clear when a start is accepted.
- R9: The raw interrupt word at offset 0x0C has calculation done in bit 0 and hash release (hash_rel_i) in bit 1. Each bit holds until software writes one to the same bit at offset 0x18. A set and a clear in the same cycle leave the bit set.
- R10: The enable word at offset 0x14 is read/write. The masked status at offset 0x10 equals raw AND enable, and irq_o is the OR of the masked bits.
- R11: Bit 0 at offset 0x08 is read/write and drives clk_force_on_o. A read of any unmapped offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 8 | Byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| cfg_o | output | 22 | Configuration fields to the engine |
| clk_force_on_o | output | 1 | Clock-gate override |
| phase_o | output | 2 | Current phase code |
| eng_start_o | output | 1 | One-cycle engine start |
| eng_done_i | input | 1 | Engine completion strobe |
| eng_pass_i | input | 1 | Verify outcome, valid with done |
| eng_kbig_i | input | 1 | k was reduced, valid with done |
| hash_rel_i | input | 1 | Hash release event |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench tries to write the configuration while a job is in progress. A design that lacked the idle gate would change the mode in the middle of a job and route it down the wrong completion path. It issues commands in the wrong phase, an engine done while idle, and a start with mode 3. A design without the phase qualifiers would leave idle or start the engine without a load. It fires a hash release and a clear in the same cycle. Giving clear the priority would lose that event. It also checks that verify skips the get phase and that a new start clears the stale result bits; a fault in either would block the bus or report the previous job's outcome.

// File: rtl/sigacc_pkg.sv
package sigacc_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOAD = 2'd1,
    PH_GET  = 2'd2,
    PH_BUSY = 2'd3
  } phase_e;

  localparam logic [1:0] MODE_VERIFY = 2'd0;
  localparam logic [1:0] MODE_GEN    = 2'd1;
  localparam logic [1:0] MODE_EXPORT = 2'd2;
  localparam logic [1:0] MODE_BAD    = 2'd3;

  localparam logic [7:0] OFS_CFG   = 8'h04;
  localparam logic [7:0] OFS_CLKG  = 8'h08;
  localparam logic [7:0] OFS_RAW   = 8'h0C;
  localparam logic [7:0] OFS_MST   = 8'h10;
  localparam logic [7:0] OFS_ENA   = 8'h14;
  localparam logic [7:0] OFS_CLR   = 8'h18;
  localparam logic [7:0] OFS_CMD   = 8'h1C;
  localparam logic [7:0] OFS_PHASE = 8'h20;
  localparam logic [7:0] OFS_RES   = 8'h24;
  localparam logic [7:0] OFS_VER   = 8'hFC;

  localparam int CMD_GO_BIT   = 0;
  localparam int CMD_LOAD_BIT = 1;
  localparam int CMD_GET_BIT  = 2;

  typedef struct packed {
    logic go;
    logic load_done;
    logic get_done;
  } cmd_t;

endpackage

// File: rtl/sigacc_regs.sv
module sigacc_regs
  import sigacc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int CFG_W  = 22,
  parameter int IRQ_N  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              idle,
  output logic [CFG_W-1:0]  cfg_q,
  output logic              clkg_q,
  output logic [IRQ_N-1:0]  ena_q,
  output logic [IRQ_N-1:0]  clr,
  output cmd_t              cmd
);

  logic wr_cfg, wr_clkg, wr_ena, wr_clr, wr_cmd;
  logic cfg_en;

  always_comb begin
    wr_cfg  = we && (addr == ADDR_W'(OFS_CFG));
    wr_clkg = we && (addr == ADDR_W'(OFS_CLKG));
    wr_ena  = we && (addr == ADDR_W'(OFS_ENA));
    wr_clr  = we && (addr == ADDR_W'(OFS_CLR));
    wr_cmd  = we && (addr == ADDR_W'(OFS_CMD));
    cfg_en  = wr_cfg && idle;
  end

  // command strobes live for the write cycle only, nothing is stored
  always_comb begin
    cmd.go        = wr_cmd && wdata[CMD_GO_BIT];
    cmd.load_done = wr_cmd && wdata[CMD_LOAD_BIT];
    cmd.get_done  = wr_cmd && wdata[CMD_GET_BIT];
    clr           = wr_clr ? wdata[IRQ_N-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_en) begin
      cfg_q <= wdata[CFG_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clkg_q <= 1'b0;
    end else if (wr_clkg) begin
      clkg_q <= wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_q <= '0;
    end else if (wr_ena) begin
      ena_q <= wdata[IRQ_N-1:0];
    end
  end

endmodule

// File: rtl/sigacc_fsm.sv
module sigacc_fsm
  import sigacc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  cmd_t       cmd,
  input  logic [1:0] mode,
  input  logic       eng_done,
  input  logic       eng_pass,
  input  logic       eng_kbig,
  output phase_e     phase,
  output logic       eng_start,
  output logic       res_pass,
  output logic       res_kwarn,
  output logic       calc_evt
);

  phase_e phase_nx;
  logic   accept_go;
  logic   fire;
  logic   res_en;
  logic   res_pass_nx, res_kwarn_nx;

  always_comb begin
    accept_go = (phase == PH_IDLE) && cmd.go && (mode != MODE_BAD);
    fire      = (phase == PH_LOAD) && cmd.load_done;
    calc_evt  = (phase == PH_BUSY) && eng_done;
    phase_nx  = phase;
    unique case (phase)
      PH_IDLE: if (accept_go) phase_nx = PH_LOAD;
      PH_LOAD: if (fire) phase_nx = PH_BUSY;
      PH_BUSY: if (eng_done) phase_nx = (mode == MODE_VERIFY) ? PH_IDLE : PH_GET;
      PH_GET:  if (cmd.get_done) phase_nx = PH_IDLE;
      default: phase_nx = PH_IDLE;
    endcase
  end

  always_comb begin
    res_en       = accept_go || calc_evt;
    res_pass_nx  = calc_evt ? eng_pass : 1'b0;
    res_kwarn_nx = calc_evt ? eng_kbig : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
    end else begin
      phase <= phase_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eng_start <= 1'b0;
    end else begin
      eng_start <= fire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_pass  <= 1'b0;
      res_kwarn <= 1'b0;
    end else if (res_en) begin
      res_pass  <= res_pass_nx;
      res_kwarn <= res_kwarn_nx;
    end
  end

endmodule

// File: rtl/sigacc_irq.sv
module sigacc_irq #(
  parameter int IRQ_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_N-1:0] evt,
  input  logic [IRQ_N-1:0] clr,
  input  logic [IRQ_N-1:0] ena,
  output logic [IRQ_N-1:0] raw,
  output logic [IRQ_N-1:0] mst,
  output logic             irq
);

  for (genvar i = 0; i < IRQ_N; i++) begin : g_src
    logic bit_en, bit_nx;
    always_comb begin
      bit_en = evt[i] || clr[i];
      bit_nx = evt[i];            // a new event wins over a clear
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        raw[i] <= 1'b0;
      end else if (bit_en) begin
        raw[i] <= bit_nx;
      end
    end
  end

  always_comb begin
    mst = raw & ena;
    irq = |mst;
  end

endmodule

// File: rtl/sigacc_ctrl.sv
module sigacc_ctrl
  import sigacc_pkg::*;
#(
  parameter int          DATA_W  = 32,
  parameter int          ADDR_W  = 8,
  parameter int          CFG_W   = 22,
  parameter logic [31:0] VERSION = 32'd36716656
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [CFG_W-1:0]  cfg_o,
  output logic              clk_force_on_o,
  output logic [1:0]        phase_o,
  output logic              eng_start_o,
  input  logic              eng_done_i,
  input  logic              eng_pass_i,
  input  logic              eng_kbig_i,
  input  logic              hash_rel_i,
  output logic              irq_o
);

  localparam int IRQ_N  = 2;
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] rst_pipe;
  logic              rst_core_n;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_N-2:0], 1'b1};
    end
  end
  assign rst_core_n = rst_pipe[SYNC_N-1];

  logic [CFG_W-1:0] cfg_q;
  logic             clkg_q;
  logic [IRQ_N-1:0] ena_q, clr_w, raw_q, mst_w, evt_w;
  cmd_t             cmd_w;
  phase_e           phase_w;
  logic             res_pass_w, res_kwarn_w, calc_evt_w;

  sigacc_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CFG_W(CFG_W), .IRQ_N(IRQ_N)
  ) u_regs (
    .clk   (clk),
    .rst_n (rst_core_n),
    .we    (bus_we),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .idle  (phase_w == PH_IDLE),
    .cfg_q (cfg_q),
    .clkg_q(clkg_q),
    .ena_q (ena_q),
    .clr   (clr_w),
    .cmd   (cmd_w)
  );

  sigacc_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .cmd      (cmd_w),
    .mode     (cfg_q[1:0]),
    .eng_done (eng_done_i),
    .eng_pass (eng_pass_i),
    .eng_kbig (eng_kbig_i),
    .phase    (phase_w),
    .eng_start(eng_start_o),
    .res_pass (res_pass_w),
    .res_kwarn(res_kwarn_w),
    .calc_evt (calc_evt_w)
  );

  assign evt_w = {hash_rel_i, calc_evt_w};

  sigacc_irq #(.IRQ_N(IRQ_N)) u_irq (
    .clk  (clk),
    .rst_n(rst_core_n),
    .evt  (evt_w),
    .clr  (clr_w),
    .ena  (ena_q),
    .raw  (raw_q),
    .mst  (mst_w),
    .irq  (irq_o)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADDR_W'(OFS_CFG):   bus_rdata[CFG_W-1:0] = cfg_q;
      ADDR_W'(OFS_CLKG):  bus_rdata[0]         = clkg_q;
      ADDR_W'(OFS_RAW):   bus_rdata[IRQ_N-1:0] = raw_q;
      ADDR_W'(OFS_MST):   bus_rdata[IRQ_N-1:0] = mst_w;
      ADDR_W'(OFS_ENA):   bus_rdata[IRQ_N-1:0] = ena_q;
      ADDR_W'(OFS_PHASE): bus_rdata[1:0]       = phase_w;
      ADDR_W'(OFS_RES):   bus_rdata[1:0]       = {res_kwarn_w, res_pass_w};
      ADDR_W'(OFS_VER):   bus_rdata            = DATA_W'(VERSION);
      default:            bus_rdata            = '0;
    endcase
  end

  assign cfg_o          = cfg_q;
  assign clk_force_on_o = clkg_q;
  assign phase_o        = phase_w;

endmodule

// File: rtl/sigacc_ctrl_chk.sv
module sigacc_ctrl_chk #(
  parameter int CFG_W = 22
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       phase_o,
  input logic [CFG_W-1:0] cfg_o,
  input logic             eng_start_o,
  input logic             irq_o,
  input logic [1:0]       raw,
  input logic [1:0]       ena,
  input logic             res_pass,
  input logic             res_kwarn
);

  AST_START_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start_o |=> !eng_start_o);                                           // R5

  AST_START_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start_o |-> (phase_o == 2'd3) && ($past(phase_o) == 2'd1));          // R5

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase_o) != 2'd0) |-> $stable(cfg_o));                            // R3

  AST_BAD_MODE_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 2'd0 && cfg_o[1:0] == 2'd3) |=> (phase_o == 2'd0));          // R7

  AST_VERIFY_NO_GET: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 2'd3 && cfg_o[1:0] == 2'd0) |=> (phase_o != 2'd2));          // R6

  AST_RESULT_CLEAR_ON_GO: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase_o) == 2'd0 && phase_o == 2'd1) |-> (!res_pass && !res_kwarn)); // R8

  AST_IRQ_NEEDS_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((raw & ena) != 2'b00));                                       // R10

endmodule

bind sigacc_ctrl sigacc_ctrl_chk #(.CFG_W(CFG_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .phase_o    (phase_o),
  .cfg_o      (cfg_o),
  .eng_start_o(eng_start_o),
  .irq_o      (irq_o),
  .raw        (raw_q),
  .ena        (ena_q),
  .res_pass   (res_pass_w),
  .res_kwarn  (res_kwarn_w)
);

// File: tb/sigacc_ctrl_test.sv
module sigacc_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic [21:0] cfg_o;
  logic        clk_force_on_o;
  logic [1:0]  phase_o;
  logic        eng_start_o;
  logic        eng_done_i = 1'b0;
  logic        eng_pass_i = 1'b0;
  logic        eng_kbig_i = 1'b0;
  logic        hash_rel_i = 1'b0;
  logic        irq_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  sigacc_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_o(cfg_o),
    .clk_force_on_o(clk_force_on_o), .phase_o(phase_o),
    .eng_start_o(eng_start_o), .eng_done_i(eng_done_i),
    .eng_pass_i(eng_pass_i), .eng_kbig_i(eng_kbig_i),
    .hash_rel_i(hash_rel_i), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = 32'h0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic engine_finish(input logic pass, input logic kbig);
    @(negedge clk);
    eng_done_i = 1'b1; eng_pass_i = pass; eng_kbig_i = kbig;
    @(negedge clk);
    eng_done_i = 1'b0; eng_pass_i = 1'b0; eng_kbig_i = 1'b0;
  endtask

  task automatic t_reset();
    rd_chk("R1 cfg", 8'h04, 32'h0);
    rd_chk("R1 clkgate", 8'h08, 32'h0);
    rd_chk("R1 raw", 8'h0C, 32'h0);
    rd_chk("R1 masked", 8'h10, 32'h0);
    rd_chk("R1 enable", 8'h14, 32'h0);
    rd_chk("R1 phase", 8'h20, 32'h0);
    rd_chk("R1 result", 8'h24, 32'h0);
    rd_chk("R1 version", 8'hFC, 32'd36716656);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    chk("R1 eng_start", {31'b0, eng_start_o}, 32'h0);
  endtask

  task automatic t_config();
    wr(8'h04, 32'hFFFF_FFFF);
    rd_chk("R2 cfg all ones", 8'h04, 32'h003F_FFFF);
    wr(8'h04, 32'h0001_2A65);
    rd_chk("R2 cfg pattern", 8'h04, 32'h0001_2A65);
    chk("R2 cfg_o", {10'b0, cfg_o}, 32'h0001_2A65);
    wr(8'h08, 32'h1);
    rd_chk("R11 clkgate set", 8'h08, 32'h1);
    chk("R11 force pin", {31'b0, clk_force_on_o}, 32'h1);
    wr(8'h08, 32'h0);
    chk("R11 force pin clr", {31'b0, clk_force_on_o}, 32'h0);
    rd_chk("R11 unmapped 00", 8'h00, 32'h0);
    rd_chk("R11 unmapped 28", 8'h28, 32'h0);
    rd_chk("R11 unmapped 80", 8'h80, 32'h0);
  endtask

  task automatic t_generate();
    wr(8'h04, 32'h0000_0041);       // mode 1
    wr(8'h1C, 32'h4);               // get-done in idle
    rd_chk("R7 get in idle", 8'h20, 32'h0);
    wr(8'h1C, 32'h1);
    rd_chk("R5 load phase", 8'h20, 32'h1);
    rd_chk("R4 cmd reads zero", 8'h1C, 32'h0);
    wr(8'h04, 32'h0000_0002);
    rd_chk("R3 cfg locked", 8'h04, 32'h0000_0041);
    engine_finish(1'b1, 1'b1);      // stray done in load
    rd_chk("R7 done in load", 8'h20, 32'h1);
    rd_chk("R7 no raw from stray done", 8'h0C, 32'h0);
    wr(8'h1C, 32'h2);
    rd_chk("R5 busy phase", 8'h20, 32'h3);
    chk("R5 eng_start high", {31'b0, eng_start_o}, 32'h1);
    @(negedge clk);
    chk("R5 eng_start one cycle", {31'b0, eng_start_o}, 32'h0);
    wr(8'h1C, 32'h5);               // start+get in busy
    rd_chk("R7 busy ignores cmds", 8'h20, 32'h3);
    engine_finish(1'b1, 1'b1);
    rd_chk("R6 gen to get", 8'h20, 32'h2);
    rd_chk("R8 result captured", 8'h24, 32'h3);
    rd_chk("R9 calc done raw", 8'h0C, 32'h1);
    wr(8'h1C, 32'h4);
    rd_chk("R6 get-done to idle", 8'h20, 32'h0);
  endtask

  task automatic t_verify();
    wr(8'h18, 32'h3);
    rd_chk("R9 raw cleared", 8'h0C, 32'h0);
    wr(8'h04, 32'h0000_0000);
    wr(8'h1C, 32'h1);
    rd_chk("R8 result cleared on start", 8'h24, 32'h0);
    wr(8'h1C, 32'h2);
    engine_finish(1'b0, 1'b1);
    rd_chk("R6 verify to idle", 8'h20, 32'h0);
    rd_chk("R8 verify result", 8'h24, 32'h2);
  endtask

  task automatic t_export_and_bad();
    wr(8'h04, 32'h0000_0002);
    wr(8'h1C, 32'h1);
    wr(8'h1C, 32'h2);
    engine_finish(1'b0, 1'b0);
    rd_chk("R6 export to get", 8'h20, 32'h2);
    wr(8'h1C, 32'h4);
    wr(8'h04, 32'h0000_0003);
    wr(8'h1C, 32'h1);
    rd_chk("R7 bad mode stays idle", 8'h20, 32'h0);
    wr(8'h1C, 32'h2);
    rd_chk("R7 load-done in idle", 8'h20, 32'h0);
    chk("R7 no engine start", {31'b0, eng_start_o}, 32'h0);
  endtask

  task automatic t_irq();
    wr(8'h18, 32'h3);
    wr(8'h14, 32'h0);
    @(negedge clk); hash_rel_i = 1'b1;
    @(negedge clk); hash_rel_i = 1'b0;
    rd_chk("R9 hash raw", 8'h0C, 32'h2);
    rd_chk("R10 masked off", 8'h10, 32'h0);
    chk("R10 irq off", {31'b0, irq_o}, 32'h0);
    wr(8'h14, 32'h3);
    rd_chk("R10 enable read", 8'h14, 32'h3);
    rd_chk("R10 masked on", 8'h10, 32'h2);
    chk("R10 irq on", {31'b0, irq_o}, 32'h1);
    wr(8'h18, 32'h2);
    rd_chk("R9 hash cleared", 8'h0C, 32'h0);
    chk("R10 irq drops", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    hash_rel_i = 1'b1; bus_we = 1'b1; bus_addr = 8'h18; bus_wdata = 32'h2;
    @(negedge clk);
    hash_rel_i = 1'b0; bus_we = 1'b0; bus_wdata = 32'h0;
    rd_chk("R9 set beats clear", 8'h0C, 32'h2);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_config();
    t_generate();
    t_verify();
    t_export_and_bad();
    t_irq();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done_flag) begin
      done_flag = 1'b1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule